// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host processor access to a bank of 27 byte-wide internal registers through only two bus locations. The first location is the address/status port. A host write to it latches the number of the internal register to use next. A host read from it returns a live auxiliary status byte, not the latched number. The second location is the data port. It reads or writes whichever register the latched index selects, and each data access moves the index forward by one. A multi-byte field, such as the 24-bit transfer count, can therefore be loaded with one index write followed by back-to-back data writes.

Register 24 is the command register. A command accepted there starts a built-in timer stub, which keeps the command-in-progress and busy flags set for a fixed number of cycles. When the timer ends it posts an interrupt and writes a completion cause into register 23. A command written while the previous one is still running is discarded, and the discard is flagged. Register 25 is the data buffer. It does not advance the index, and it drives the data-ready flag of the status byte.

Top module: `ixp_port`

## Requirements
- R1: After reset the status byte reads 0x00, the index is 0, every register reads 0 and `cmd_start` is low.
- R2: A write to port 0 selects a register and a data write/read on port 1 reaches that register. A read of port 0 returns the status byte, not the index. Status bits 3, 2 and 1 always read 0.
- R3: Each data-port access moves the index up by one, so writing index 18 and then three data bytes fills registers 18, 19 and 20 (count high, middle, low) in that order.
- R4: The index never exceeds 26. Data accesses at 26 stay at 26, and an address write above 26 selects 26.
- R5: Data accesses at index 25 leave the index at 25. Status bit 0 (data ready) is set by a data write to register 25 and cleared by a data read of it.
- R6: A data write to register 24 while no command runs is accepted. Status bits 5 and 4 are 1 from the next cycle for CMD_BUSY_CYCLES cycles, then both clear, status bit 7 (interrupt) is set, and register 23 becomes 0x10.
- R7: A data write to register 24 while a command runs is dropped: register 24 keeps its value, no launch occurs, and status bit 6 is set. The next accepted command clears bit 6.
- R8: A data-port read of register 23 clears status bit 7.
- R9: An accepted command gives a one-cycle `cmd_start` pulse in the next cycle, with `cmd_code` equal to the low 7 bits of the written byte and `cmd_single` equal to its bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_port | input | 1 | 0 = address/status port, 1 = data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of the access |
| cmd_start | output | 1 | One-cycle pulse per accepted command |
| cmd_code | output | 7 | Code of the last accepted command |
| cmd_single | output | 1 | Single-byte qualifier of the last accepted command |

## Verification
Read data is combinational from registered state. A read returns its value in the same cycle as the access, and the effects of any write show up from the following cycle. The busy bits rise in the first cycle after an accepted command write and stay up for CMD_BUSY_CYCLES cycles. The interrupt bit appears in the cycle after that, and `cmd_start` pulses in the cycle right after the write. The bench drives each access 2 ns after a rising edge and compares reads at the falling edge, and it places its status reads on the last busy cycle and the first idle cycle.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_REGS  = 27;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int IDX_LAST  = NUM_REGS - 1;
    localparam int IDX_CAUSE = 23;
    localparam int IDX_CMD   = 24;
    localparam int IDX_DATA  = 25;

    localparam logic [REG_W-1:0] CAUSE_DONE = 8'h10;

    localparam int ST_IRQ  = 7;
    localparam int ST_LCI  = 6;
    localparam int ST_BSY  = 5;
    localparam int ST_CIP  = 4;
    localparam int ST_PERR = 1;
    localparam int ST_DBR  = 0;

    typedef enum logic {
        PORT_ADDR = 1'b0,
        PORT_DATA = 1'b1
    } port_e;
endpackage

// File: rtl/ixp_index.sv
module ixp_index
    import ixp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_wr,
    input  logic [REG_W-1:0]     sel_val,
    input  logic                 step,
    output logic [IDX_W-1:0]     idx
);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(IDX_LAST);
    localparam logic [IDX_W-1:0] DATA_I = IDX_W'(IDX_DATA);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            if (sel_val > REG_W'(IDX_LAST))
                st_d.idx = LAST_I;
            else
                st_d.idx = sel_val[IDX_W-1:0];
        end else if (step && st_q.idx != DATA_I && st_q.idx != LAST_I) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= LAST_I); // R4
    AST_DATA_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sel_wr && st_q.idx == DATA_I) |=> (st_q.idx == DATA_I)); // R5
endmodule

// File: rtl/ixp_cmd_timer.sv
module ixp_cmd_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch)
            st_d.cnt = CNT_W'(CYCLES);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
    assign done = (st_q.cnt == CNT_W'(1));

    initial begin
        if (CYCLES < 1) $error("CYCLES must be at least 1");
    end

    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy); // R7
    AST_BUSY_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy); // R6
endmodule

// File: rtl/ixp_regbank.sv
module ixp_regbank
    import ixp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 cause_wr,
    input  logic [REG_W-1:0]     cause_val,
    output logic [REG_W-1:0]     rdata,
    output logic                 dbr
);
    localparam logic [IDX_W-1:0] DATA_I = IDX_W'(IDX_DATA);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] regs;
        logic                           full;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.regs[idx] = wdata;
            if (idx == DATA_I) st_d.full = 1'b1;
        end else if (rd_en && idx == DATA_I) begin
            st_d.full = 1'b0;
        end
        if (cause_wr) st_d.regs[IDX_CAUSE] = cause_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.regs[idx];
    assign dbr   = st_q.full;

    AST_DBR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == DATA_I) |=> dbr); // R5
    AST_DBR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && idx == DATA_I) |=> !dbr); // R5
endmodule

// File: rtl/ixp_port.sv
module ixp_port
    import ixp_pkg::*;
#(
    parameter int CMD_BUSY_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cs,
    input  logic             host_we,
    input  logic             host_port,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             cmd_start,
    output logic [6:0]       cmd_code,
    output logic             cmd_single
);
    localparam logic [IDX_W-1:0] CMD_I   = IDX_W'(IDX_CMD);
    localparam logic [IDX_W-1:0] CAUSE_I = IDX_W'(IDX_CAUSE);

    typedef struct packed {
        logic       irq;
        logic       lci;
        logic       start;
        logic [6:0] code;
        logic       single;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] bank_rdata;
    logic             dbr, busy, done;
    logic             addr_wr, data_acc, data_wr, data_rd;
    logic             cmd_hit, accept, drop, bank_we, cause_rd;
    logic [REG_W-1:0] status;

    assign addr_wr  = host_cs && host_we && (host_port == PORT_ADDR);
    assign data_acc = host_cs && (host_port == PORT_DATA);
    assign data_wr  = data_acc && host_we;
    assign data_rd  = data_acc && !host_we;
    assign cmd_hit  = data_wr && (idx == CMD_I);
    assign accept   = cmd_hit && !busy;
    assign drop     = cmd_hit && busy;
    assign bank_we  = data_wr && !drop;
    assign cause_rd = data_rd && (idx == CAUSE_I);

    ixp_index u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (addr_wr),
        .sel_val (host_wdata),
        .step    (data_acc),
        .idx     (idx)
    );

    ixp_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_we),
        .rd_en     (data_rd),
        .idx       (idx),
        .wdata     (host_wdata),
        .cause_wr  (done),
        .cause_val (CAUSE_DONE),
        .rdata     (bank_rdata),
        .dbr       (dbr)
    );

    ixp_cmd_timer #(.CYCLES(CMD_BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (accept),
        .busy   (busy),
        .done   (done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (accept) begin
            st_d.start  = 1'b1;
            st_d.code   = host_wdata[6:0];
            st_d.single = host_wdata[7];
            st_d.lci    = 1'b0;
        end
        if (drop)     st_d.lci = 1'b1;
        if (cause_rd) st_d.irq = 1'b0;
        if (done)     st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status          = '0;
        status[ST_IRQ]  = st_q.irq;
        status[ST_LCI]  = st_q.lci;
        status[ST_BSY]  = busy;
        status[ST_CIP]  = busy;
        status[ST_PERR] = 1'b0;
        status[ST_DBR]  = dbr;
    end

    assign host_rdata = (host_port == PORT_ADDR) ? status : bank_rdata;
    assign cmd_start  = st_q.start;
    assign cmd_code   = st_q.code;
    assign cmd_single = st_q.single;

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> st_q.lci); // R7
    AST_DROP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !cmd_start); // R7
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> st_q.irq); // R6
    AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !done) |=> !st_q.irq); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> busy); // R9
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R9
endmodule

// File: tb/ixp_port_tb.sv
module ixp_port_tb_top;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0;
    logic       host_we = 1'b0;
    logic       host_port = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cmd_start;
    logic [6:0] cmd_code;
    logic       cmd_single;

    always #5 clk = ~clk;

    ixp_port #(.CMD_BUSY_CYCLES(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_we    (host_we),
        .host_port  (host_port),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cmd_start  (cmd_start),
        .cmd_code   (cmd_code),
        .cmd_single (cmd_single)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic [6:0] seen_code = '0;
    logic       seen_single = 1'b0;

    task automatic check_eq(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic port, logic [7:0] val);
        @(posedge clk); #2;
        host_cs = 1'b1; host_we = 1'b1; host_port = port; host_wdata = val;
    endtask

    task automatic rd(logic port, logic [7:0] exp, string tag);
        item_t it;
        @(posedge clk); #2;
        host_cs = 1'b1; host_we = 1'b0; host_port = port; host_wdata = '0;
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            host_cs = 1'b0; host_we = 1'b0;
        end
    endtask

    // Monitor: compares every read against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && host_cs && !host_we) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL unexpected read: got %02h expected none", host_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check_eq(it.tag, int'(host_rdata), int'(it.exp));
            end
        end
        if (rst_n && cmd_start) begin
            pulses++;
            seen_code = cmd_code;
            seen_single = cmd_single;
        end
    end

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        check_eq("R1 cmd_start after reset", int'(cmd_start), 0);

        // R1: reset state
        rd(0, 8'h00, "R1 status after reset");
        rd(1, 8'h00, "R1 reg0 after reset");

        // R2: select, write, read back; port 0 read is status
        wr(0, 8'd3);
        wr(1, 8'hA5);
        wr(0, 8'd3);
        rd(1, 8'hA5, "R2 reg3 readback");
        wr(0, 8'd7);
        rd(0, 8'h00, "R2 port0 reads status not index");

        // R3: transfer count via auto-increment
        wr(0, 8'd18);
        wr(1, 8'h12);
        wr(1, 8'h34);
        wr(1, 8'h56);
        wr(0, 8'd18);
        rd(1, 8'h12, "R3 count high");
        rd(1, 8'h34, "R3 count middle");
        rd(1, 8'h56, "R3 count low");
        rd(1, 8'h00, "R3 reg21 untouched");

        // R4: saturation at 26 and clamped address
        wr(0, 8'd26);
        wr(1, 8'h11);
        wr(1, 8'h22);
        wr(0, 8'd26);
        rd(1, 8'h22, "R4 index held at 26");
        wr(0, 8'hFF);
        rd(1, 8'h22, "R4 address above 26 clamps");

        // R5: data register holds index, data-ready flag
        wr(0, 8'd25);
        wr(1, 8'h3C);
        rd(0, 8'h01, "R5 data ready set");
        rd(1, 8'h3C, "R5 first read of reg25");
        rd(0, 8'h00, "R5 data ready cleared");
        rd(1, 8'h3C, "R5 index stays at 25");

        // R6 / R9: accepted command and busy window
        pulses = 0;
        wr(0, 8'd24);
        wr(1, 8'h87);
        rd(0, 8'h30, "R6 busy first cycle");
        idle(N - 2);
        rd(0, 8'h30, "R6 busy last cycle");
        rd(0, 8'h80, "R6 irq after busy");
        idle(1);
        check_eq("R9 one launch pulse", pulses, 1);
        check_eq("R9 command code", int'(seen_code), 7);
        check_eq("R9 single-byte flag", int'(seen_single), 1);
        wr(0, 8'd23);
        rd(1, 8'h10, "R6 completion cause");
        rd(0, 8'h00, "R8 irq cleared by cause read");

        // R7: command while busy is dropped
        pulses = 0;
        wr(0, 8'd24);
        wr(1, 8'h05);
        wr(0, 8'd24);
        wr(1, 8'h7E);
        rd(0, 8'h70, "R7 ignored flag while busy");
        idle(N);
        rd(0, 8'hC0, "R7 flag kept after completion");
        wr(0, 8'd24);
        rd(1, 8'h05, "R7 command register unchanged");
        check_eq("R7 single launch despite second write", pulses, 1);
        check_eq("R9 command code low bits", int'(seen_code), 5);
        check_eq("R9 single flag clear", int'(seen_single), 0);
        wr(0, 8'd23);
        rd(1, 8'h10, "R8 cause read");
        wr(0, 8'd24);
        wr(1, 8'h01);
        rd(0, 8'h30, "R7 ignored flag cleared by accepted command");
        idle(N + 2);
        wr(0, 8'd23);
        rd(1, 8'h10, "R6 cause after second command");
        rd(0, 8'h00, "R8 final status");
        idle(2);

        check_eq("scoreboard drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule